// File: doc/BRIEF.md
# GPU Command Packet Framer

This block sits on the drawing-command word port of a graphics processor. It accepts a stream of 32-bit words and groups them into whole command packets. The top byte of the first word is the opcode. The opcode fixes the packet length, or, for polylines, the rule by which a terminator word closes the packet. Words are held in an internal buffer, and nothing leaves until the last word of a packet has arrived.

Complete drawing packets go to a downstream rasterizer one word per handshake, with a marker on the final word. Image-transfer headers and VRAM-to-VRAM copy headers do not use that port. Each is presented whole on its own valid/ready side channel. When an image-write header is taken, the block pulses a flag so that the pixel-payload path can begin.

Environment-setting opcodes write into a bank of eight shadow registers. Two of those registers feed a small status field. Opcodes that carry no parameters and are not environment commands are dropped without any output.

Top module: `gpu_pkt_framer`

## Requirements
- R1: After reset, inReady is 1, drawValid, xferValid, copyValid, polyErr and payloadStart are 0, statusBits is 0, and shadow register i (envRegs bits 32*i+31 : 32*i) holds the opcode 0xE0+i in bits 31:24 with all other bits 0.
- R2: Drawing packets have these total word counts: opcode 0x02 gives 3 words; 0x20-0x23 give 4; 0x24-0x27 give 7; 0x28-0x2B give 5; 0x2C-0x2F give 9; 0x30-0x33 give 6; 0x34-0x37 give 9; 0x38-0x3B give 8; 0x3C-0x3F give 12; 0x40-0x47 give 3; 0x50-0x57 give 4. drawValid stays 0 until the last word of the packet is accepted. The words then leave in arrival order, with drawLast high only on the final one.
- R3: For opcodes 0x60-0x7F, the packet length is 2 words. One more word is added when bits 4:3 are 00 (a size word), and one more when bit 2 is 1 (a texture word). The exception is bits 4:3 = 01 together with bit 2 = 1 (0x6C-0x6F): those words are dropped as no-ops.
- R4: For opcodes 0x48-0x4F, every word at index 3 or later is tested. A word W ends the packet when (W & 0xF000F000) == 0x50005000. The terminator is emitted as the last word of the packet.
- R5: For opcodes 0x58-0x5F, the terminator test from R4 applies only at even indices of 4 or more. A word that matches the pattern at an odd index is passed along as ordinary data.
- R6: A polyline that reaches DEPTH words without a terminator is closed at DEPTH words. polyErr is high for the one cycle after its last word is accepted. polyErr stays 0 when a polyline ends on a terminator.
- R7: Opcodes 0xA0-0xDF collect 3 words, which appear as xferHdr, xferPos and xferSize with xferValid. xferRead is 1 when header bits 31:29 are 110. For a write (bits 31:29 = 101), payloadStart is 1 for the one cycle after the xferValid/xferReady handshake.
- R8: Opcodes 0x80-0x9F collect 4 words. Words 1, 2 and 3 appear as copySrc, copyDst and copySize with copyValid.
- R9: A word whose bits 31:27 are 11100 is stored whole into shadow register bits 26:24. It produces no packet on any output channel.
- R10: One clock after the cycle in which a shadow register is written, statusBits 10:0 take shadow register 1 bits 10:0, and statusBits 12:11 take shadow register 6 bits 1:0.
- R11: Opcodes 0x00, 0x6C-0x6F and 0xE8-0xFF are consumed as single words. They produce no output and change no shadow register and no status bit.
- R12: While any output channel holds a packet, inReady is 0. Under back-pressure, drawWord and drawLast stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWord | input | 32 | Incoming command word |
| inValid | input | 1 | inWord is valid |
| inReady | output | 1 | Block accepts inWord this cycle |
| drawWord | output | 32 | Current word of a drawing packet |
| drawLast | output | 1 | drawWord is the final word of its packet |
| drawValid | output | 1 | Drawing word is valid |
| drawReady | input | 1 | Downstream takes drawWord |
| xferHdr | output | 32 | Image-transfer header word |
| xferPos | output | 32 | Image-transfer position word |
| xferSize | output | 32 | Image-transfer size word |
| xferRead | output | 1 | Transfer reads VRAM (1) or writes it (0) |
| xferValid | output | 1 | Transfer header set is valid |
| xferReady | input | 1 | Downstream takes the transfer header set |
| payloadStart | output | 1 | One-cycle pulse: image-write payload phase begins |
| copySrc | output | 32 | Copy source position word |
| copyDst | output | 32 | Copy destination position word |
| copySize | output | 32 | Copy size word |
| copyValid | output | 1 | Copy header set is valid |
| copyReady | input | 1 | Downstream takes the copy header set |
| polyErr | output | 1 | One-cycle pulse: polyline closed at the length limit |
| statusBits | output | 13 | Status field taken from shadow registers 1 and 6 |
| envRegs | output | 256 | Shadow registers 0..7, register i in bits 32*i+31 : 32*i |

## Verification
The checks assume that downstream ready signals can go low at any time, and that the source may hold inValid high while inReady is 0. The stimulus therefore stalls the drawing port and keeps offering a word during that stall. The status check assumes the status field changes only through environment words accepted two samples earlier, so the bench never forces the shadow registers through any other path. Filler words use a top nibble of 1, so they can never look like a polyline terminator. Terminators and near-terminators are placed only where a test intends them.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

  typedef enum logic [2:0] {
    CL_DROP,
    CL_ENV,
    CL_DRAW,
    CL_MONO,
    CL_SHADE,
    CL_XFER,
    CL_COPY
  } cls_e;

  typedef struct packed {
    cls_e       cls;
    logic [3:0] words;  // total words for fixed kinds, minimum for polylines
  } dec_t;

  typedef struct packed {
    logic store;
    logic clear;
    logic shadowWr;
    logic refresh;
    logic advRead;
  } strobe_t;

  function automatic dec_t decodeOp(input logic [7:0] op);
    dec_t d;
    d.cls   = CL_DROP;
    d.words = 4'd1;
    if (op == 8'h02) begin
      d.cls = CL_DRAW; d.words = 4'd3;
    end else if (op[7:5] == 3'b001) begin
      d.cls = CL_DRAW;
      case (op[4:2])
        3'd0:    d.words = 4'd4;
        3'd1:    d.words = 4'd7;
        3'd2:    d.words = 4'd5;
        3'd3:    d.words = 4'd9;
        3'd4:    d.words = 4'd6;
        3'd5:    d.words = 4'd9;
        3'd6:    d.words = 4'd8;
        default: d.words = 4'd12;
      endcase
    end else if (op[7:3] == 5'b01000) begin
      d.cls = CL_DRAW; d.words = 4'd3;
    end else if (op[7:3] == 5'b01001) begin
      d.cls = CL_MONO; d.words = 4'd4;
    end else if (op[7:3] == 5'b01010) begin
      d.cls = CL_DRAW; d.words = 4'd4;
    end else if (op[7:3] == 5'b01011) begin
      d.cls = CL_SHADE; d.words = 4'd5;
    end else if (op[7:5] == 3'b011) begin
      if (op[4:3] == 2'b01 && op[2]) begin
        d.cls = CL_DROP;
      end else begin
        d.cls   = CL_DRAW;
        d.words = 4'd2 + {3'd0, op[4:3] == 2'b00} + {3'd0, op[2]};
      end
    end else if (op[7:5] == 3'b100) begin
      d.cls = CL_COPY; d.words = 4'd4;
    end else if (op[7:5] == 3'b101 || op[7:5] == 3'b110) begin
      d.cls = CL_XFER; d.words = 4'd3;
    end else if (op[7:3] == 5'b11100) begin
      d.cls = CL_ENV;
    end
    return d;
  endfunction

  function automatic logic isTerm(input logic [31:0] w);
    return (w & 32'hF000_F000) == 32'h5000_5000;
  endfunction

endpackage

// File: rtl/gpf_datapath.sv
module gpf_datapath
  import gpf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [31:0]   inWord,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          lastRd,
  output logic [31:0]   drawWord,
  output logic [31:0]   xferHdr,
  output logic [31:0]   xferPos,
  output logic [31:0]   xferSize,
  output logic [31:0]   copySrc,
  output logic [31:0]   copyDst,
  output logic [31:0]   copySize,
  output logic [12:0]   statusBits,
  output logic [255:0]  envRegs
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int NSH = 8;

  logic [31:0]   bufMem [DEPTH];
  logic [IW-1:0] readIdx;
  logic [IW-1:0] wrIdx;
  logic [31:0]   shadow [NSH];

  assign wrIdx = count[IW-1:0];

  always_ff @(posedge clk) begin
    if (strb.store) bufMem[wrIdx] <= inWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      readIdx <= '0;
    end else if (strb.clear) begin
      count   <= '0;
      readIdx <= '0;
    end else begin
      if (strb.store)   count   <= count + CW'(1);
      if (strb.advRead) readIdx <= readIdx + IW'(1);
    end
  end

  assign lastRd   = (CW'(readIdx) + CW'(1)) == count;
  assign drawWord = bufMem[readIdx];
  assign xferHdr  = bufMem[0];
  assign xferPos  = bufMem[1];
  assign xferSize = bufMem[2];
  assign copySrc  = bufMem[1];
  assign copyDst  = bufMem[2];
  assign copySize = bufMem[3];

  for (genvar g = 0; g < NSH; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN)
        shadow[g] <= {8'(8'hE0 + g), 24'h0};
      else if (strb.shadowWr && inWord[26:24] == 3'(g))
        shadow[g] <= inWord;
    end
    assign envRegs[32*g +: 32] = shadow[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      statusBits <= '0;
    else if (strb.refresh)
      statusBits <= {shadow[6][1:0], shadow[1][10:0]};
  end

endmodule

// File: rtl/gpf_ctrl.sv
module gpf_ctrl
  import gpf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [31:0]   inWord,
  input  logic          inValid,
  output logic          inReady,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic          lastRd,
  output logic          drawValid,
  input  logic          drawReady,
  output logic          xferValid,
  input  logic          xferReady,
  output logic          xferRead,
  output logic          payloadStart,
  output logic          copyValid,
  input  logic          copyReady,
  output logic          polyErr,
  output strobe_t       strb
);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_GATHER, S_DRAW, S_XFER, S_COPY} state_e;

  state_e     state, nextState;
  cls_e       kind;
  logic [3:0] target;
  logic       isRd;
  logic       envPend;
  dec_t       dec;
  logic       term;
  logic       gatherDone;
  logic       forceEnd;
  logic       startPkt;

  assign dec  = decodeOp(inWord[31:24]);
  assign term = isTerm(inWord);

  always_comb begin
    strb       = '0;
    inReady    = 1'b0;
    drawValid  = 1'b0;
    xferValid  = 1'b0;
    copyValid  = 1'b0;
    nextState  = state;
    gatherDone = 1'b0;
    forceEnd   = 1'b0;
    startPkt   = 1'b0;
    case (state)
      S_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          case (dec.cls)
            CL_ENV:  strb.shadowWr = 1'b1;
            CL_DROP: ;
            default: begin
              strb.store = 1'b1;
              startPkt   = 1'b1;
              nextState  = S_GATHER;
            end
          endcase
        end
      end
      S_GATHER: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.store = 1'b1;
          case (kind)
            CL_MONO: begin
              gatherDone = (count >= CW'(3)) && term;
              forceEnd   = !gatherDone && (count == CW'(DEPTH - 1));
            end
            CL_SHADE: begin
              gatherDone = (count >= CW'(4)) && !count[0] && term;
              forceEnd   = !gatherDone && (count == CW'(DEPTH - 1));
            end
            default: gatherDone = (count + CW'(1)) == CW'(target);
          endcase
          if (gatherDone || forceEnd) begin
            case (kind)
              CL_XFER: nextState = S_XFER;
              CL_COPY: nextState = S_COPY;
              default: nextState = S_DRAW;
            endcase
          end
        end
      end
      S_DRAW: begin
        drawValid = 1'b1;
        if (drawReady) begin
          strb.advRead = 1'b1;
          if (lastRd) begin
            strb.clear = 1'b1;
            nextState  = S_IDLE;
          end
        end
      end
      S_XFER: begin
        xferValid = 1'b1;
        if (xferReady) begin
          strb.clear = 1'b1;
          nextState  = S_IDLE;
        end
      end
      S_COPY: begin
        copyValid = 1'b1;
        if (copyReady) begin
          strb.clear = 1'b1;
          nextState  = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
    strb.refresh = envPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      kind         <= CL_DROP;
      target       <= '0;
      isRd         <= 1'b0;
      envPend      <= 1'b0;
      polyErr      <= 1'b0;
      payloadStart <= 1'b0;
    end else begin
      state        <= nextState;
      envPend      <= strb.shadowWr;
      polyErr      <= forceEnd;
      payloadStart <= (state == S_XFER) && xferReady && !isRd;
      if (startPkt) begin
        kind   <= dec.cls;
        target <= dec.words;
        isRd   <= inWord[31:29] == 3'b110;
      end
    end
  end

  assign xferRead = isRd;

endmodule

// File: rtl/gpu_pkt_framer.sv
module gpu_pkt_framer
  import gpf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [31:0]  inWord,
  input  logic         inValid,
  output logic         inReady,
  output logic [31:0]  drawWord,
  output logic         drawLast,
  output logic         drawValid,
  input  logic         drawReady,
  output logic [31:0]  xferHdr,
  output logic [31:0]  xferPos,
  output logic [31:0]  xferSize,
  output logic         xferRead,
  output logic         xferValid,
  input  logic         xferReady,
  output logic         payloadStart,
  output logic [31:0]  copySrc,
  output logic [31:0]  copyDst,
  output logic [31:0]  copySize,
  output logic         copyValid,
  input  logic         copyReady,
  output logic         polyErr,
  output logic [12:0]  statusBits,
  output logic [255:0] envRegs
);
  localparam int CW = $clog2(DEPTH + 1);

  strobe_t       strb;
  logic [CW-1:0] count;
  logic          lastRd;

  gpf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid), .inReady(inReady),
    .count(count), .lastRd(lastRd), .drawValid(drawValid), .drawReady(drawReady),
    .xferValid(xferValid), .xferReady(xferReady), .xferRead(xferRead),
    .payloadStart(payloadStart), .copyValid(copyValid), .copyReady(copyReady),
    .polyErr(polyErr), .strb(strb)
  );

  gpf_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inWord(inWord), .count(count),
    .lastRd(lastRd), .drawWord(drawWord), .xferHdr(xferHdr), .xferPos(xferPos),
    .xferSize(xferSize), .copySrc(copySrc), .copyDst(copyDst), .copySize(copySize),
    .statusBits(statusBits), .envRegs(envRegs)
  );

  assign drawLast = lastRd;

endmodule

// File: rtl/gpf_chk.sv
module gpf_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] inWord,
  input logic        inValid,
  input logic        inReady,
  input logic [31:0] drawWord,
  input logic        drawLast,
  input logic        drawValid,
  input logic        drawReady,
  input logic        xferValid,
  input logic        xferReady,
  input logic        xferRead,
  input logic        copyValid,
  input logic        payloadStart,
  input logic        polyErr,
  input logic [12:0] statusBits
);
  logic envAccept;
  assign envAccept = inValid && inReady && (inWord[31:27] == 5'b11100);

  a_r12_draw_hold: assert property (@(posedge clk) disable iff (!rstN)
    drawValid && !drawReady |=> drawValid && $stable(drawWord) && $stable(drawLast));

  a_r12_no_intake: assert property (@(posedge clk) disable iff (!rstN)
    (drawValid || xferValid || copyValid) |-> !inReady);

  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drawValid, xferValid, copyValid}));

  a_r6_err_with_packet: assert property (@(posedge clk) disable iff (!rstN)
    polyErr |-> drawValid);

  a_r7_payload_after_write: assert property (@(posedge clk) disable iff (!rstN)
    payloadStart |-> $past(xferValid && xferReady && !xferRead));

  a_r10_status_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusBits) |-> $past(envAccept, 2));
endmodule

bind gpu_pkt_framer gpf_chk u_chk (.*);

// File: tb/gpu_pkt_framer_bench.sv
module gpu_pkt_framer_bench;
  localparam int DEPTH = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  inWord = '0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [31:0]  drawWord;
  logic         drawLast;
  logic         drawValid;
  logic         drawReady = 1'b0;
  logic [31:0]  xferHdr, xferPos, xferSize;
  logic         xferRead, xferValid;
  logic         xferReady = 1'b0;
  logic         payloadStart;
  logic [31:0]  copySrc, copyDst, copySize;
  logic         copyValid;
  logic         copyReady = 1'b0;
  logic         polyErr;
  logic [12:0]  statusBits;
  logic [255:0] envRegs;

  always #4 clk = ~clk;

  gpu_pkt_framer #(.DEPTH(DEPTH)) u_gpu_pkt_framer (.*);

  int nChecks = 0;
  int nErrs = 0;
  bit finished = 0;
  logic [31:0] got [32];

  // {header, total words, channel: 0 draw, 1 transfer, 2 copy}
  localparam logic [41:0] VEC [21] = '{
    {32'h02_001122, 8'd3, 2'd0}, {32'h20_0000AA, 8'd4, 2'd0},
    {32'h24_0000AB, 8'd7, 2'd0}, {32'h28_0000AC, 8'd5, 2'd0},
    {32'h2C_0000AD, 8'd9, 2'd0}, {32'h30_0000AE, 8'd6, 2'd0},
    {32'h34_0000AF, 8'd9, 2'd0}, {32'h38_0000B0, 8'd8, 2'd0},
    {32'h3C_0000B1, 8'd12, 2'd0}, {32'h40_0000B2, 8'd3, 2'd0},
    {32'h52_0000B3, 8'd4, 2'd0}, {32'h60_0000C0, 8'd3, 2'd0},
    {32'h64_0000C1, 8'd4, 2'd0}, {32'h68_0000C2, 8'd2, 2'd0},
    {32'h70_0000C3, 8'd2, 2'd0}, {32'h74_0000C4, 8'd3, 2'd0},
    {32'h78_0000C5, 8'd2, 2'd0}, {32'h7C_0000C6, 8'd3, 2'd0},
    {32'hA0_000001, 8'd3, 2'd1}, {32'hC0_000002, 8'd3, 2'd1},
    {32'h80_000003, 8'd4, 2'd2}
  };

  function automatic logic [31:0] fill(input int k);
    return 32'h1000_0000 | 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inWord = w;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic takeDraw(output int n);
    bit done;
    n = 0;
    done = 0;
    drawReady = 1'b1;
    for (int t = 0; t < 64; t++) begin
      if (drawValid) begin
        got[n] = drawWord;
        n++;
        done = drawLast;
      end
      @(negedge clk);
      if (done) break;
    end
    drawReady = 1'b0;
  endtask

  function automatic logic [31:0] shadowOf(input int i);
    return envRegs[32*i +: 32];
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nErrs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] hdr;
    int len;
    logic [1:0] ch;
    string tag;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(inReady && !drawValid && !xferValid && !copyValid && !polyErr && !payloadStart,
        "R1", {inReady, drawValid, xferValid, copyValid}, 4'b1000);
    chk(statusBits == 13'h0, "R1", statusBits, 0);
    chk(shadowOf(3) == 32'hE300_0000, "R1", shadowOf(3), 32'hE300_0000);
    chk(shadowOf(7) == 32'hE700_0000, "R1", shadowOf(7), 32'hE700_0000);

    // table walk: R2 R3 R7 R8
    for (int v = 0; v < 21; v++) begin
      hdr = VEC[v][41:10];
      len = int'(VEC[v][9:2]);
      ch  = VEC[v][1:0];
      tag = (ch == 2'd1) ? "R7" : (ch == 2'd2) ? "R8" : (hdr[31:29] == 3'b011) ? "R3" : "R2";
      sendWord(hdr);
      for (int k = 1; k < len; k++) begin
        if (k == len - 1)
          chk(!drawValid && !xferValid && !copyValid, "R2 partial held", {drawValid, xferValid, copyValid}, 0);
        sendWord(fill(k));
      end
      if (ch == 2'd0) begin
        takeDraw(n);
        chk(n == len, tag, n, len);
        chk(got[0] == hdr && got[n-1] == fill(len - 1), tag, got[n-1], fill(len - 1));
      end else if (ch == 2'd1) begin
        chk(xferValid && xferHdr == hdr && xferPos == fill(1) && xferSize == fill(2), "R7",
            xferSize, fill(2));
        chk(xferRead == (hdr[31:29] == 3'b110), "R7 direction", xferRead, hdr[31:29] == 3'b110);
        xferReady = 1'b1;
        @(negedge clk);
        xferReady = 1'b0;
        chk(payloadStart == (hdr[31:29] == 3'b101), "R7 payload pulse", payloadStart, hdr[31:29] == 3'b101);
        chk(!xferValid, "R7 released", xferValid, 0);
      end else begin
        chk(copyValid && copySrc == fill(1) && copyDst == fill(2) && copySize == fill(3), "R8",
            copySize, fill(3));
        copyReady = 1'b1;
        @(negedge clk);
        copyReady = 1'b0;
        chk(!copyValid, "R8 released", copyValid, 0);
      end
    end

    // R4 mono polyline, terminator at index 4
    sendWord(32'h48_000010); sendWord(fill(1)); sendWord(fill(2)); sendWord(fill(3));
    sendWord(32'h5555_5555);
    chk(!polyErr, "R6 no error on terminator", polyErr, 0);
    takeDraw(n);
    chk(n == 5 && got[4] == 32'h5555_5555, "R4", n, 5);

    // R4 shortest mono polyline
    sendWord(32'h4A_000011); sendWord(fill(1)); sendWord(fill(2)); sendWord(32'h5000_5000);
    takeDraw(n);
    chk(n == 4, "R4 minimum", n, 4);

    // R5 shaded: pattern at odd index 3 ignored, terminator at index 6
    sendWord(32'h58_000012); sendWord(fill(1)); sendWord(fill(2)); sendWord(32'h5000_5000);
    sendWord(fill(4)); sendWord(fill(5)); sendWord(32'h5ABC_5DEF);
    takeDraw(n);
    chk(n == 7 && got[3] == 32'h5000_5000 && got[6] == 32'h5ABC_5DEF, "R5", n, 7);

    // R6 forced termination at DEPTH words
    sendWord(32'h4C_000013);
    for (int k = 1; k < DEPTH; k++) sendWord(fill(k));
    chk(polyErr, "R6 error pulse", polyErr, 1);
    takeDraw(n);
    chk(n == DEPTH, "R6 length", n, DEPTH);

    // R9 / R10 shadow write and status timing
    sendWord(32'hE100_0ABC);
    chk(shadowOf(1) == 32'hE100_0ABC && !drawValid && !xferValid && !copyValid, "R9",
        shadowOf(1), 32'hE100_0ABC);
    chk(statusBits == 13'h0, "R10 one cycle later", statusBits, 0);
    @(negedge clk);
    chk(statusBits == 13'h02BC, "R10 low field", statusBits, 13'h02BC);
    sendWord(32'hE600_0003);
    @(negedge clk);
    chk(statusBits == 13'h1ABC, "R10 high field", statusBits, 13'h1ABC);

    // R11 dropped opcodes
    sendWord(32'h0000_0000); sendWord(32'h6C00_0001); sendWord(32'hE812_3456); sendWord(32'hF900_0000);
    @(negedge clk);
    chk(inReady && !drawValid && !xferValid && !copyValid, "R11 no output",
        {inReady, drawValid, xferValid, copyValid}, 4'b1000);
    chk(shadowOf(0) == 32'hE000_0000 && shadowOf(1) == 32'hE100_0ABC && statusBits == 13'h1ABC,
        "R11 state untouched", shadowOf(0), 32'hE000_0000);

    // R12 back-pressure while a word is offered
    sendWord(32'h40_0000D0); sendWord(fill(1)); sendWord(fill(2));
    inWord = 32'hE100_07FF;
    inValid = 1'b1;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      chk(drawValid && !inReady && drawWord == 32'h40_0000D0 && !drawLast, "R12 hold",
          drawWord, 32'h40_0000D0);
    end
    inValid = 1'b0;
    takeDraw(n);
    chk(n == 3, "R12 packet intact", n, 3);
    @(negedge clk);
    chk(shadowOf(1) == 32'hE100_0ABC && statusBits == 13'h1ABC, "R12 word not taken",
        shadowOf(1), 32'hE100_0ABC);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrs);
    $finish;
  end
endmodule